// File: doc/BRIEF.md
# Two-latch interlocked ALU pipeline

This block is a small in-order execution pipeline for register-to-register arithmetic. An instruction word is read from an external instruction memory at the current program counter and enters the first latch, but only when the fetch request is high. On the cycle it leaves the first latch, it reads its two source registers. The second latch computes the sum or difference and writes the result into the register file as the instruction retires. Any opcode other than add or subtract passes through the pipeline and retires without writing anything.

There is no bypass network. When the instruction retiring from the second latch targets a register that the instruction in the first latch still has to read, the first latch holds its instruction. A bubble goes into the second latch and no fetch is taken. A retire port shows each retiring instruction, and a flushed output reports an empty pipeline. With fetch held low, the register file then matches what one-at-a-time execution of every fetched instruction would produce.

Top module: `interlock_pipe`

## Requirements
- R1: After reset, the program counter is 0, both latches are empty so `flushed` is 1 and `retireValid` is 0, and register k holds the value k.
- R2: Opcode 0 (word bits [11:9]) writes the 16-bit wrapped sum reg[ra]+reg[rb] into reg[rc], where rc is bits [8:6], ra is bits [5:3] and rb is bits [2:0].
- R3: Opcode 1 writes the 16-bit wrapped difference reg[ra]-reg[rb] into reg[rc].
- R4: Opcodes 2 to 7 retire with `retireWe` low and leave every register unchanged.
- R5: A fetch is taken only when `fetchEn` is 1 and there is no stall. Each fetch moves `imemAddr` up by one, wrapping at the address width, and the word at the old address enters the first latch.
- R6: A stall exists when both latches are valid and the second latch's rc equals the first latch's ra or rb. During a stall the first latch keeps its instruction, the next cycle shows no retirement, and no fetch is taken, whatever `fetchEn` is.
- R7: Source operands are read from the register file when the instruction moves from the first latch to the second. A result written at retirement is seen by every instruction that moves later.
- R8: Instructions retire one per cycle at most, in fetch order. `retireValid`, `retireDest` and `retireData` describe the instruction in the second latch during the cycle it retires.
- R9: `flushed` is 1 exactly when both latches are empty. With `fetchEn` held at 0, the pipeline becomes flushed within 3 cycles and stays flushed.
- R10: Once the pipeline is flushed, the register file equals sequential execution of all fetched instructions, and the number of retirements equals the number of fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchEn | input | 1 | Request to fetch one instruction this cycle |
| imemAddr | output | 8 | Instruction memory read address (program counter) |
| imemData | input | 12 | Instruction word at `imemAddr` |
| flushed | output | 1 | Both latches are empty |
| retireValid | output | 1 | An instruction retires this cycle |
| retireWe | output | 1 | The retiring instruction writes the register file |
| retireDest | output | 3 | Destination register of the retiring instruction |
| retireData | output | 16 | Value written by the retiring instruction |

## Verification
A fetch request and a stall can arrive in the same cycle. The fetch must then be refused while the held instruction waits for its producer to retire. Random programs draw register indices from a narrow set and keep `fetchEn` high for long runs, so a fetch request often lands on a stall cycle. A behavioural cycle model in the bench predicts the program counter, the bubble and every retirement, and these are compared on every clock. Retirement and the operand read of a younger instruction also share cycles. The drain at the end of each program checks that the register file written through the retire port matches a purely sequential execution.

// File: rtl/interlock_pipe_pkg.sv
package interlock_pipe_pkg;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;

  typedef struct packed {
    logic takeFetch;
    logic advance;
    logic stall;
    logic retire;
  } pipeStrobes_t;

endpackage

// File: rtl/interlock_pipe_ctrl.sv
module interlock_pipe_ctrl
  import interlock_pipe_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchEn,
  input  logic [IDX_W-1:0] l1Ra,
  input  logic [IDX_W-1:0] l1Rb,
  input  logic [IDX_W-1:0] l2Rc,
  output pipeStrobes_t     strobes,
  output logic             flushed
);

  logic l1Valid, l2Valid;
  logic hazard;

  assign hazard = l1Valid && l2Valid && ((l2Rc == l1Ra) || (l2Rc == l1Rb));

  always_comb begin
    strobes.stall     = hazard;
    strobes.takeFetch = fetchEn && !hazard;
    strobes.advance   = l1Valid && !hazard;
    strobes.retire    = l2Valid;
  end

  assign flushed = !l1Valid && !l2Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l1Valid <= 1'b0;
      l2Valid <= 1'b0;
    end else if (hazard) begin
      l2Valid <= 1'b0;
    end else begin
      l2Valid <= l1Valid;
      l1Valid <= fetchEn;
    end
  end

endmodule

// File: rtl/interlock_pipe_datapath.sv
module interlock_pipe_datapath
  import interlock_pipe_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int NREGS = 8,
  parameter int PC_W  = 8,
  parameter int OP_W  = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  pipeStrobes_t                      strobes,
  input  logic [OP_W+3*$clog2(NREGS)-1:0]   imemData,
  output logic [PC_W-1:0]                   imemAddr,
  output logic [$clog2(NREGS)-1:0]          l1Ra,
  output logic [$clog2(NREGS)-1:0]          l1Rb,
  output logic [$clog2(NREGS)-1:0]          l2Rc,
  output logic                              retireWe,
  output logic [REG_W-1:0]                  retireData
);

  localparam int IDX_W   = $clog2(NREGS);
  localparam int INSTR_W = OP_W + 3 * IDX_W;
  localparam int RB_LO   = 0;
  localparam int RA_LO   = IDX_W;
  localparam int RC_LO   = 2 * IDX_W;
  localparam int OP_LO   = 3 * IDX_W;

  logic [PC_W-1:0]    pcReg;
  logic [INSTR_W-1:0] l1Word;
  logic [OP_W-1:0]    l2Op;
  logic [IDX_W-1:0]   l2Dest;
  logic [REG_W-1:0]   l2OpA, l2OpB;
  logic [REG_W-1:0]   regFile [NREGS];
  logic [REG_W-1:0]   aluOut;
  logic               isArith;

  assign imemAddr = pcReg;
  assign l1Ra     = l1Word[RA_LO +: IDX_W];
  assign l1Rb     = l1Word[RB_LO +: IDX_W];
  assign l2Rc     = l2Dest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg  <= '0;
      l1Word <= '0;
    end else if (strobes.takeFetch) begin
      pcReg  <= pcReg + 1'b1;
      l1Word <= imemData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l2Op   <= '0;
      l2Dest <= '0;
      l2OpA  <= '0;
      l2OpB  <= '0;
    end else if (strobes.advance) begin
      l2Op   <= l1Word[OP_LO +: OP_W];
      l2Dest <= l1Word[RC_LO +: IDX_W];
      l2OpA  <= regFile[l1Ra];
      l2OpB  <= regFile[l1Rb];
    end
  end

  always_comb begin
    isArith = 1'b1;
    aluOut  = l2OpA;
    if (l2Op == OP_W'(OP_ADD)) begin
      aluOut = l2OpA + l2OpB;
    end else if (l2Op == OP_W'(OP_SUB)) begin
      aluOut = l2OpA - l2OpB;
    end else begin
      isArith = 1'b0;
    end
  end

  assign retireWe   = strobes.retire && isArith;
  assign retireData = aluOut;

  for (genvar g = 0; g < NREGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[g] <= REG_W'(g);
      end else if (retireWe && (l2Dest == IDX_W'(g))) begin
        regFile[g] <= aluOut;
      end
    end
  end

endmodule

// File: rtl/interlock_pipe.sv
module interlock_pipe
  import interlock_pipe_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int NREGS = 8,
  parameter int PC_W  = 8,
  parameter int OP_W  = 3
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                fetchEn,
  output logic [PC_W-1:0]                     imemAddr,
  input  logic [OP_W+3*$clog2(NREGS)-1:0]     imemData,
  output logic                                flushed,
  output logic                                retireValid,
  output logic                                retireWe,
  output logic [$clog2(NREGS)-1:0]            retireDest,
  output logic [REG_W-1:0]                    retireData
);

  localparam int IDX_W = $clog2(NREGS);

  pipeStrobes_t     strobes;
  logic [IDX_W-1:0] l1Ra, l1Rb, l2Rc;
  logic             stallNow;

  assign stallNow    = strobes.stall;
  assign retireValid = strobes.retire;
  assign retireDest  = l2Rc;

  interlock_pipe_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .fetchEn (fetchEn),
    .l1Ra    (l1Ra),
    .l1Rb    (l1Rb),
    .l2Rc    (l2Rc),
    .strobes (strobes),
    .flushed (flushed)
  );

  interlock_pipe_datapath #(
    .REG_W (REG_W),
    .NREGS (NREGS),
    .PC_W  (PC_W),
    .OP_W  (OP_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .imemData   (imemData),
    .imemAddr   (imemAddr),
    .l1Ra       (l1Ra),
    .l1Rb       (l1Rb),
    .l2Rc       (l2Rc),
    .retireWe   (retireWe),
    .retireData (retireData)
  );

endmodule

// File: rtl/interlock_pipe_chk.sv
module interlock_pipe_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            fetchEn,
  input logic [PC_W-1:0] imemAddr,
  input logic            flushed,
  input logic            retireValid,
  input logic            retireWe,
  input logic            stall
);

  // R6: a stalled cycle takes no fetch
  assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(imemAddr));

  // R6: a stalled cycle sends a bubble into the second latch
  assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !retireValid);

  // R6: a stall needs a non-empty pipeline
  assert_stall_not_flushed_R6: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !flushed);

  // R5: an accepted fetch steps the address by one
  assert_fetch_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn && !stall) |=> (imemAddr == $past(imemAddr) + 1'b1));

  // R5: no request, no address change
  assert_no_request_R5: assert property (@(posedge clk) disable iff (!rstN)
    !fetchEn |=> $stable(imemAddr));

  // R4: a register write only comes with a retirement
  assert_write_needs_retire_R4: assert property (@(posedge clk) disable iff (!rstN)
    retireWe |-> retireValid);

  // R9: an empty pipeline with no request stays empty
  assert_stays_flushed_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flushed && !fetchEn) |=> flushed);

  // R9: an empty pipeline retires nothing
  assert_flushed_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushed |-> !retireValid);

endmodule

bind interlock_pipe interlock_pipe_chk #(.PC_W(PC_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .fetchEn     (fetchEn),
  .imemAddr    (imemAddr),
  .flushed     (flushed),
  .retireValid (retireValid),
  .retireWe    (retireWe),
  .stall       (stallNow)
);

// File: tb/tb_interlock_pipe.sv
`timescale 1ns/1ps
module tb_interlock_pipe;

  localparam int NREGS = 8;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchEn = 1'b0;
  logic [7:0]  imemAddr;
  logic [11:0] imemData;
  logic        flushed, retireValid, retireWe;
  logic [2:0]  retireDest;
  logic [15:0] retireData;

  logic [11:0] imem [DEPTH];
  assign imemData = imem[imemAddr];

  always #2 clk = ~clk;

  interlock_pipe dut (
    .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .imemAddr(imemAddr),
    .imemData(imemData), .flushed(flushed), .retireValid(retireValid),
    .retireWe(retireWe), .retireDest(retireDest), .retireData(retireData)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // cycle model state
  bit          m1v, m2v;
  logic [11:0] m1ins;
  logic [2:0]  m2op, m2rc;
  logic [15:0] m2a, m2b;
  logic [7:0]  mPc;
  logic [15:0] mRegs [NREGS];
  // sequential model and retire-port shadow
  logic [15:0] seqRegs [NREGS];
  logic [15:0] shadow [NREGS];
  int          fetched, retired, stallsSeen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] alu(input logic [2:0] op, input logic [15:0] a, b);
    return (op == 3'd0) ? a + b : a - b;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    fetchEn = 1'b0;
    m1v = 0; m2v = 0; mPc = '0; m1ins = '0;
    m2op = '0; m2rc = '0; m2a = '0; m2b = '0;
    for (int k = 0; k < NREGS; k++) begin
      mRegs[k] = 16'(k); seqRegs[k] = 16'(k); shadow[k] = 16'(k);
    end
    fetched = 0; retired = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 flushed", flushed, 1);
    check("R1 imemAddr", imemAddr, 0);
    check("R1 retireValid", retireValid, 0);
  endtask

  // compare at the negative edge, then advance the model by one clock
  task automatic cycle(input bit fe);
    bit hz;
    logic [15:0] na, nb;
    logic [2:0] op, rc, ra, rb;
    hz = m1v && m2v && ((m2rc == m1ins[5:3]) || (m2rc == m1ins[2:0]));
    check("R9 flushed", flushed, !(m1v || m2v));
    check(hz ? "R6 imemAddr" : "R5 imemAddr", imemAddr, mPc);
    check("R8 retireValid", retireValid, m2v);
    if (m2v) begin
      check(m2op < 2 ? "R2 retireWe" : "R4 retireWe", retireWe, m2op < 2);
      check("R8 retireDest", retireDest, m2rc);
      if (m2op < 2)
        check(m2op == 0 ? "R2 retireData" : "R3 retireData", retireData, alu(m2op, m2a, m2b));
    end
    if (retireValid) retired++;
    if (retireWe) shadow[retireDest] = retireData;
    if (hz) stallsSeen++;
    fetchEn = fe;
    // operands read before the retiring write lands (R7)
    na = mRegs[m1ins[5:3]];
    nb = mRegs[m1ins[2:0]];
    if (m2v && m2op < 2) mRegs[m2rc] = alu(m2op, m2a, m2b);
    if (hz) begin
      m2v = 0;
    end else begin
      m2v = m1v; m2op = m1ins[11:9]; m2rc = m1ins[8:6]; m2a = na; m2b = nb;
      if (fe) begin
        m1v = 1; m1ins = imem[mPc]; mPc = mPc + 1'b1; fetched++;
        op = m1ins[11:9]; rc = m1ins[8:6]; ra = m1ins[5:3]; rb = m1ins[2:0];
        if (op < 2) seqRegs[rc] = alu(op, seqRegs[ra], seqRegs[rb]);
      end else begin
        m1v = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic runProgram(input int cycles, input int fetchPct, input bit narrow);
    int waitCnt;
    for (int a = 0; a < DEPTH; a++) begin
      logic [2:0] op, rc, ra, rb;
      op = (($urandom % 8) < 6) ? 3'($urandom % 2) : 3'(2 + $urandom % 6);
      rc = narrow ? 3'($urandom % 2) : 3'($urandom % 8);
      ra = narrow ? 3'($urandom % 2) : 3'($urandom % 8);
      rb = narrow ? 3'($urandom % 3) : 3'($urandom % 8);
      imem[a] = {op, rc, ra, rb};
    end
    doReset();
    for (int c = 0; c < cycles; c++) cycle(($urandom % 100) < fetchPct);
    // R9: drain with fetch held low
    waitCnt = 0;
    while (!flushed && waitCnt < 6) begin
      cycle(1'b0);
      waitCnt++;
    end
    check("R9 drain cycles", waitCnt <= 3, 1);
    cycle(1'b0);
    cycle(1'b0);
    check("R9 stays flushed", flushed, 1);
    // R10: architectural state equals sequential execution
    for (int k = 0; k < NREGS; k++) check("R10 register", shadow[k], seqRegs[k]);
    check("R10 retire count", retired, fetched);
  endtask

  initial begin
    stallsSeen = 0;
    for (int a = 0; a < DEPTH; a++) imem[a] = '0;
    runProgram(400, 100, 1'b1);
    runProgram(400, 100, 1'b0);
    runProgram(400, 60, 1'b1);
    runProgram(400, 30, 1'b0);
    runProgram(300, 85, 1'b1);
    runProgram(600, 95, 1'b0);
    // R6: the narrow programs must have produced stalls
    check("R6 stalls provoked", stallsSeen > 0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule